// File: doc/BRIEF.md
# Replicated Round-Robin Bus Arbitration Slice

This block is one arbitration slice of a synchronous backplane bus that has no central arbiter. An identical copy sits in every module slot. Each slot drives its own request line, and that line is wired to every slice, so every copy sees the same request vector. Every copy therefore holds the same priority state and reaches the same decision in the same bus cycle. A slice pulses its grant output only when the winning slot is its own local slot. Every slice also publishes the winning slot number and a valid flag.

Arbitration uses lines that are separate from the data path, so a new award can be made while earlier transfers are still moving data. Transfers are pipelined and non-pended: once granted, a transfer runs to completion. Each slice counts the transfers in flight. It stops awarding when the count reaches the configured cap, which defaults to three. The transfer tracker returns a one-cycle completion pulse when a transfer ends. Later transfer phases are timed from the cycle in which the award appears.

Top module: `bus_arb_slice`

## Requirements
- R1: After an asynchronous active-low reset, `grant_o` and `win_valid_o` are 0, the priority pointer is slot 0 and the in-flight count is 0. The first award after reset, with all request lines high, goes to slot 0.
- R2: In a cycle where no request bit is set, no award is made: `win_valid_o` and `grant_o` are 0 in the following cycle.
- R3: The winner is the first slot with its request bit set, searching upward from the priority pointer and wrapping from slot NUM_SLOTS-1 to slot 0. Bit k of `req_i` is the request from slot k.
- R4: After each award the pointer moves to the winner plus one, modulo NUM_SLOTS. When no award is made, the pointer does not change.
- R5: `grant_o` is 1 for exactly the cycle in which `win_valid_o` is 1 and `win_slot_o` equals the value `slot_id_i` had in the arbitration cycle. In every other cycle it is 0.
- R6: While MAX_OUT transfers (default 3) are in flight, no award is made, even with requests pending.
- R7: The in-flight count rises by one per award and falls by one per `done_i` pulse. An award and a `done_i` in the same cycle leave the count unchanged. A `done_i` while the count is zero is ignored.
- R8: Requests sampled at one rising clock edge produce the award outputs visible after that edge. At most one award is made per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SLOTS | Request line from every slot; bit k belongs to slot k |
| slot_id_i | input | SLOT_W | Slot number of the local module |
| done_i | input | 1 | One-cycle completion pulse from the transfer tracker |
| grant_o | output | 1 | Local module owns the transfer slot just awarded |
| win_valid_o | output | 1 | An award was made in the last arbitration cycle |
| win_slot_o | output | SLOT_W | Slot number of the last winner |

## Verification
The stimulus uses all-ones requests to show pointer rotation. Sparse patterns such as slots 3 and 7 force the search to skip idle slots and to wrap. A lone requester shows that the same slot can win repeatedly once the pointer has passed it. Bursts of awards against the in-flight cap separate the blocking case from the case where completion and award arrive together. A completion pulse at zero count separates a saturating counter from one that wraps around. Changing the local slot number separates a broadcast grant from a grant qualified by the local slot.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned DEF_SLOTS   = 8;
  localparam int unsigned DEF_MAX_OUT = 3;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned NUM_SLOTS = arb_pkg::DEF_SLOTS,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] req_i,
  input  logic [SLOT_W-1:0]    ptr_i,
  output logic                 hit_o,
  output logic [SLOT_W-1:0]    win_o
);
  // scan upward from ptr, wrap, first hit wins
  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      int unsigned idx;
      idx = (int'(ptr_i) + i) % NUM_SLOTS;
      if (!hit_o && req_i[idx]) begin
        hit_o = 1'b1;
        win_o = SLOT_W'(idx);
      end
    end
  end
endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
  parameter int unsigned MAX_OUT = arb_pkg::DEF_MAX_OUT,
  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             award_i,
  input  logic             done_i,
  output logic             room_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign dec    = done_i && (cnt_q != '0);
  assign room_o = (cnt_q < CNT_W'(MAX_OUT));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (award_i && !dec) cnt_q <= cnt_q + 1'b1;
    else if (!award_i && dec) cnt_q <= cnt_q - 1'b1;
  end

  assert_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_OUT));
  assert_zero_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && done_i && !award_i) |=> (cnt_q == '0));
  assert_balance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (award_i && done_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/bus_arb_slice.sv
module bus_arb_slice #(
  parameter int unsigned NUM_SLOTS = arb_pkg::DEF_SLOTS,
  parameter int unsigned MAX_OUT   = arb_pkg::DEF_MAX_OUT,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W    = $clog2(MAX_OUT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] req_i,
  input  logic [SLOT_W-1:0]    slot_id_i,
  input  logic                 done_i,
  output logic                 grant_o,
  output logic                 win_valid_o,
  output logic [SLOT_W-1:0]    win_slot_o
);
  logic [SLOT_W-1:0] ptr_q, ptr_nxt;
  logic              hit, room, award;
  logic [SLOT_W-1:0] pick;
  logic [CNT_W-1:0]  cnt;

  rr_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .req_i (req_i),
    .ptr_i (ptr_q),
    .hit_o (hit),
    .win_o (pick)
  );

  credit_ctr #(.MAX_OUT(MAX_OUT)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .award_i (award),
    .done_i  (done_i),
    .room_o  (room),
    .cnt_o   (cnt)
  );

  assign award   = hit && room;
  assign ptr_nxt = (pick == SLOT_W'(NUM_SLOTS - 1)) ? '0 : pick + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      win_valid_o <= 1'b0;
      win_slot_o  <= '0;
      grant_o     <= 1'b0;
    end else begin
      win_valid_o <= award;
      grant_o     <= award && (pick == slot_id_i);
      if (award) begin
        ptr_q      <= ptr_nxt;
        win_slot_o <= pick;
      end
    end
  end

  assert_winner_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    award |-> req_i[pick]);
  assert_no_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> !win_valid_o);
  assert_full_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(MAX_OUT)) |=> !win_valid_o);
  assert_grant_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> win_valid_o);
  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !award |=> $stable(ptr_q));
  assert_ptr_move_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (ptr_q == ((win_slot_o == SLOT_W'(NUM_SLOTS - 1)) ? '0 : win_slot_o + 1'b1)));
endmodule

// File: tb/tb_bus_arb_slice.sv
`timescale 1ns/1ps
module tb_bus_arb_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [2:0] sid = '0;
  logic       done = 1'b0;
  logic       grant, wvalid;
  logic [2:0] wslot;
  int errors = 0;
  int checks = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  bus_arb_slice dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .slot_id_i(sid), .done_i(done),
    .grant_o(grant), .win_valid_o(wvalid), .win_slot_o(wslot)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       done;
    logic [2:0] id;
    logic       v;
    logic [2:0] slot;
    logic       g;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'hFF, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1},
    '{8'hFF, 1'b1, 3'd3, 1'b1, 3'd1, 1'b0},
    '{8'h88, 1'b0, 3'd3, 1'b1, 3'd3, 1'b1},
    '{8'h88, 1'b0, 3'd7, 1'b1, 3'd7, 1'b1},
    '{8'hFF, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'hFF, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h06, 1'b0, 3'd2, 1'b1, 3'd1, 1'b0},
    '{8'h00, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h00, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h00, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h00, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h01, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1},
    '{8'h01, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1},
    '{8'h01, 1'b1, 3'd0, 1'b1, 3'd0, 1'b1},
    '{8'h01, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1},
    '{8'h01, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h02, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0},
    '{8'h80, 1'b0, 3'd7, 1'b1, 3'd7, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    timed_out = 1'b1;
  end

  initial begin
    // R1: reset state
    #12;
    chk("R1 valid in reset", int'(wvalid), 0);
    chk("R1 grant in reset", int'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV && !timed_out; i++) begin
      @(negedge clk);
      req = TBL[i].req; done = TBL[i].done; sid = TBL[i].id;
      @(negedge clk);
      req = '0; done = 1'b0;
      // R8: result visible one edge after sampling
      if (TBL[i].req == 8'h00)
        chk($sformatf("R2 vec%0d valid", i), int'(wvalid), 0);
      else if (!TBL[i].v)
        chk($sformatf("R6 R7 vec%0d valid", i), int'(wvalid), 0);
      else begin
        chk($sformatf("R8 vec%0d valid", i), int'(wvalid), 1);
        chk($sformatf("R3 R4 vec%0d slot", i), int'(wslot), int'(TBL[i].slot));
      end
      chk($sformatf("R5 vec%0d grant", i), int'(grant), int'(TBL[i].g));
    end

    // R5: grant lasts one cycle when requests stop (count now 3 -> free it)
    @(negedge clk);
    chk("R5 grant pulse ends", int'(grant), 0);

    // R1: mid-run reset restores pointer to slot 0
    rst_n = 1'b0;
    #2;
    chk("R1 async reset valid", int'(wvalid), 0);
    chk("R1 async reset grant", int'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;
    req = 8'hFF; sid = 3'd0;
    @(negedge clk);
    req = '0;
    chk("R1 first winner slot", int'(wslot), 0);
    chk("R1 first winner grant", int'(grant), 1);

    // R3: wrap from pointer 1 past top to slot 0 only
    req = 8'h01; sid = 3'd5;
    @(negedge clk);
    req = '0;
    chk("R3 wrap slot", int'(wslot), 0);
    chk("R5 foreign grant", int'(grant), 0);

    if (timed_out) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge timed_out) begin
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule